// File: doc/BRIEF.md
# Three-Phase Bridge Dead-Time Controller

This block sits between a motor-control PWM generator and the gate drivers of a three-leg half-bridge inverter. For every leg it takes a low-side request, which is active high, and a high-side request, which is active low. From these it produces registered enables for the two switches of the leg. Turning a switch on waits for a programmable number of clock cycles, while turning it off takes effect at once. Because of this, the two switches of a leg are never conducting together.

The low-side request wins over the high-side request. If both inputs of a leg are wired to one PWM wire, a 1 selects the low switch, a 0 selects the high switch, and dead time is inserted on every edge. Several controls override the normal path. A disable and an undervoltage flag shut every switch off. A force input from a separate startup-refresh sequencer turns every low switch on and every high switch off. A bypass control removes the interlock so that each enable simply follows its own request.

Top module: `bridge_deadtime`

## Requirements
- R1: While `rst_n` is low at a clock edge, all six enables are 0 after that edge and every pending delay is cancelled.
- R2: In normal mode, `lo_cmd[i]`=1 requests the low switch of leg i and keeps `hi_en[i]` at 0 whatever `hi_cmd_n[i]` is.
- R3: In normal mode, `lo_cmd[i]`=0 with `hi_cmd_n[i]`=0 requests the high switch. `lo_cmd[i]`=0 with `hi_cmd_n[i]`=1 requests neither switch.
- R4: A switch whose request goes away is disabled at the very next clock edge, with no delay.
- R5: Turn-on delay works as follows. A request is first sampled at edge k. If `dead_cycles` holds N at edge k, the enable rises at edge k+N. N=0 gives turn-on at edge k itself. Later changes of `dead_cycles` do not affect a delay that is already running.
- R6: If a request drops before its delay has finished, the delay is cancelled. The next request starts a full new delay.
- R7: With `bypass`=1 (and no disable, undervoltage or force), after each edge `lo_en`=`lo_cmd` and `hi_en`=~`hi_cmd_n`, so both switches of a leg may be on together.
- R8: `dis`=1 at an edge makes all six enables 0 after that edge, overriding every other input.
- R9: `uv`=1 at an edge makes all six enables 0 after that edge.
- R10: `refresh`=1 (without `dis` or `uv`) makes `lo_en`=3'b111 and `hi_en`=3'b000 after the edge, overriding `bypass` and the commands.
- R11: Whenever `bypass` was 0 at the last edge, no leg has `lo_en` and `hi_en` both at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_cmd | input | 3 | Low-side requests, active high, bit i = leg i |
| hi_cmd_n | input | 3 | High-side requests, active low, bit i = leg i |
| dis | input | 1 | Global disable, highest priority |
| uv | input | 1 | Undervoltage flag, forces all switches off |
| refresh | input | 1 | Startup-refresh force: all low on, all high off |
| bypass | input | 1 | Removes turn-on delays and the interlock |
| dead_cycles | input | 16 | Turn-on delay in clock cycles, common to all legs |
| lo_en | output | 3 | Registered low-side gate enables |
| hi_en | output | 3 | Registered high-side gate enables |

## Verification
A delay counter left holding a wrong value shows up at the ports as an enable that rises one or more edges early or late after a request. If a timer stays armed after its request drops, a later request turns on too early. Either fault appears within `dead_cycles`+1 cycles of the request and is caught on that cycle, because the reference model is compared on every clock. A stale enable register that survives an override or a mode change is visible on the very next edge. Any error in the priority order is also visible on the next edge, and with bypass off it can also show as two enables of one leg high together.

// File: rtl/bridge_deadtime.sv
module bridge_deadtime #(
  parameter int PHASES = 3,
  parameter int CW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] lo_cmd,
  input  logic [PHASES-1:0] hi_cmd_n,
  input  logic              dis,
  input  logic              uv,
  input  logic              refresh,
  input  logic              bypass,
  input  logic [CW-1:0]     dead_cycles,
  output logic [PHASES-1:0] lo_en,
  output logic [PHASES-1:0] hi_en
);
  localparam int CH = 2 * PHASES;

  logic [CH-1:0] req, direct, en_q;
  logic          kill, normal;

  assign req    = {~lo_cmd & ~hi_cmd_n, lo_cmd};
  assign direct = {~hi_cmd_n, lo_cmd};
  assign kill   = dis | uv;
  assign normal = !kill && !refresh && !bypass;

  for (genvar g = 0; g < CH; g++) begin : g_sw
    logic          en_r, arm_r;
    logic [CW-1:0] cnt_r;
    always_ff @(posedge clk) begin
      if (!rst_n || kill) begin
        en_r  <= 1'b0;
        arm_r <= 1'b0;
        cnt_r <= '0;
      end else if (refresh) begin
        en_r  <= (g < PHASES) ? 1'b1 : 1'b0;
        arm_r <= 1'b0;
      end else if (bypass) begin
        en_r  <= direct[g];
        arm_r <= 1'b0;
      end else if (!req[g]) begin
        en_r  <= 1'b0;
        arm_r <= 1'b0;
      end else if (!en_r) begin
        if (!arm_r) begin
          if (dead_cycles == '0) en_r <= 1'b1;
          else begin
            arm_r <= 1'b1;
            cnt_r <= dead_cycles - 1'b1;
          end
        end else if (cnt_r == '0) begin
          en_r  <= 1'b1;
          arm_r <= 1'b0;
        end else begin
          cnt_r <= cnt_r - 1'b1;
        end
      end
    end
    assign en_q[g] = en_r;
  end

  assign lo_en = en_q[PHASES-1:0];
  assign hi_en = en_q[CH-1:PHASES];

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bypass) |-> ((lo_en & hi_en) == '0));
  p_low_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    normal |=> ((hi_en & $past(lo_cmd)) == '0));
  p_fast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh && !bypass) |=> ((lo_en & ~$past(lo_cmd)) == '0));
  p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !kill && !refresh) |=> (lo_en == $past(lo_cmd) && hi_en == ~$past(hi_cmd_n)));
  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (lo_en == '0 && hi_en == '0));
  p_undervolt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (lo_en == '0 && hi_en == '0));
  p_refresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !kill) |=> (lo_en == '1 && hi_en == '0));
endmodule

// File: tb/tb_bridge_deadtime.sv
module tb_bridge_deadtime;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] lo_cmd = '0, hi_cmd_n = '1;
  logic dis = 1'b0, uv = 1'b0, refresh = 1'b0, bypass = 1'b0;
  logic [15:0] dead_cycles = '0;
  logic [2:0] lo_en, hi_en;

  always #10 clk = ~clk;

  bridge_deadtime dut (.clk(clk), .rst_n(rst_n), .lo_cmd(lo_cmd), .hi_cmd_n(hi_cmd_n),
    .dis(dis), .uv(uv), .refresh(refresh), .bypass(bypass), .dead_cycles(dead_cycles),
    .lo_en(lo_en), .hi_en(hi_en));

  int vectors = 0, errors = 0;
  int run [6];
  int dts [6];
  bit exp_en [6];
  bit byp_last = 1'b0, started = 1'b0, done = 1'b0;
  string tag = "R1";

  // reference: counts consecutive requested cycles, turns on once count exceeds the sampled delay
  always @(posedge clk) begin
    bit rq, dr;
    for (int i = 0; i < 6; i++) begin
      rq = (i < 3) ? lo_cmd[i] : (!lo_cmd[i-3] && !hi_cmd_n[i-3]);
      dr = (i < 3) ? lo_cmd[i] : !hi_cmd_n[i-3];
      if (!rst_n || dis || uv) begin exp_en[i] = 0; run[i] = 0; end
      else if (refresh) begin exp_en[i] = (i < 3); run[i] = 0; end
      else if (bypass) begin exp_en[i] = dr; run[i] = 0; end
      else if (!rq) begin exp_en[i] = 0; run[i] = 0; end
      else if (!exp_en[i]) begin
        if (run[i] == 0) dts[i] = int'(dead_cycles);
        run[i]++;
        exp_en[i] = (run[i] > dts[i]);
      end
    end
    byp_last = bypass;
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [2:0] el, eh;
      for (int i = 0; i < 3; i++) begin el[i] = exp_en[i]; eh[i] = exp_en[i+3]; end
      vectors++;
      if (lo_en !== el || hi_en !== eh) begin
        errors++;
        $display("FAIL %s: lo_en=%b hi_en=%b expected lo_en=%b hi_en=%b", tag, lo_en, hi_en, el, eh);
      end
      if (!byp_last && ((lo_en & hi_en) != 0)) begin
        errors++;
        $display("FAIL R11: overlap lo_en=%b hi_en=%b expected no common bit", lo_en, hi_en);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    tag = "R1"; lo_cmd = 3'b111; hi_cmd_n = 3'b000; cyc(4);
    rst_n = 1'b1; lo_cmd = 3'b000; hi_cmd_n = 3'b111; cyc(2);
    tag = "R2"; dead_cycles = 16'd3; lo_cmd = 3'b001; hi_cmd_n = 3'b000; cyc(8);
    tag = "R3"; lo_cmd = 3'b000; cyc(8);
    hi_cmd_n = 3'b101; cyc(3);
    tag = "R4"; hi_cmd_n = 3'b111; cyc(3);
    tag = "R5"; dead_cycles = 16'd0; lo_cmd = 3'b111; cyc(3);
    lo_cmd = 3'b000; hi_cmd_n = 3'b000; cyc(3);
    dead_cycles = 16'd6; lo_cmd = 3'b010; hi_cmd_n = 3'b111; cyc(2);
    dead_cycles = 16'd1; cyc(8);
    tag = "R6"; dead_cycles = 16'd4;
    for (int k = 0; k < 4; k++) begin lo_cmd = 3'b100; cyc(3); lo_cmd = 3'b000; cyc(1); end
    lo_cmd = 3'b100; cyc(7);
    tag = "R7"; bypass = 1'b1; lo_cmd = 3'b011; hi_cmd_n = 3'b100; cyc(3);
    lo_cmd = 3'b100; hi_cmd_n = 3'b011; cyc(2);
    bypass = 1'b0; cyc(6);
    tag = "R8"; dis = 1'b1; refresh = 1'b1; bypass = 1'b1; cyc(3);
    refresh = 1'b0; bypass = 1'b0; cyc(2); dis = 1'b0; cyc(6);
    tag = "R9"; uv = 1'b1; refresh = 1'b1; cyc(3); uv = 1'b0; refresh = 1'b0; cyc(6);
    tag = "R10"; refresh = 1'b1; bypass = 1'b1; hi_cmd_n = 3'b000; lo_cmd = 3'b000; cyc(4);
    refresh = 1'b0; bypass = 1'b0; cyc(7);
    tag = "R1"; rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
    tag = "R11";
    for (int k = 0; k < 3000; k++) begin
      lo_cmd = 3'($urandom); hi_cmd_n = 3'($urandom);
      if ($urandom_range(0, 15) == 0) dead_cycles = 16'($urandom_range(0, 7));
      dis = ($urandom_range(0, 63) == 0);
      uv = ($urandom_range(0, 63) == 0);
      refresh = ($urandom_range(0, 63) == 0);
      bypass = ($urandom_range(0, 31) == 0);
      cyc($urandom_range(1, 6));
    end
    dis = 1'b0; uv = 1'b0; refresh = 1'b0; bypass = 1'b0; cyc(10);
    finish_run();
  end
endmodule